// File: doc/BRIEF.md
# Bus Activity Monitor with Watermark Interrupts

This block watches bus activity on several channels and raises interrupts when the traffic level moves out of a programmed band. Each channel has a plain event pulse input. Every pulse adds a programmable weight to a running tally. At the end of each sampling period the tally becomes that period's count, and the tally starts again from zero. The count updates an exponential moving average whose window length is set by a shift field.

The raw period count is checked against a high and a low threshold. A separate run counter for each direction tracks how many periods in a row crossed its threshold. When a run reaches its programmed length, a sticky status bit is set. The new average is checked against its own high and low thresholds, and those checks also set sticky status bits. A channel's interrupt is the OR of its status bits whose enables are set. The block's interrupt output is the OR of all channel interrupts. A global status word shows which channels are interrupting.

Software reaches all registers through a simple single-cycle register port. A write takes effect at the clock edge. Reads are combinational from the address. No streaming data crosses the block's edge, so there is no valid/ready handshake and nothing can apply back-pressure. The event inputs and the interrupt output are plain level pins.

Top module: `activity_monitor`

## Requirements
- R1: Global registers sit at 0x000 (status, read-only) and 0x004 (period). Channel i has a 64-byte window at 0x1C0 + 0x40*i. Within a window the offsets are:
  - 0x00 control
  - 0x04 high threshold
  - 0x08 low threshold
  - 0x0C average load
  - 0x10 average high threshold
  - 0x14 average low threshold
  - 0x18 weight
  - 0x20 average readback
  - 0x24 status

  Writable registers read back the value written.
- R2: A sampling period lasts (P+1)*UNIT_CYCLES clock cycles, where P is the period register (reset value 11). Writing the period register restarts the timing, so the period ends in the (P+1)*UNIT_CYCLES-th cycle after the write edge.
- R3: Each event pulse sampled during a period adds the weight to that period's count. An event sampled on the period's last cycle counts toward the next period.
- R4: At each period end the average becomes avg - (avg >> (K+1)) + (count >> (K+1)), with K taken from control bits 12:10. A write to the average-load offset sets the average directly.
- R5: A count strictly above the high threshold is a high period. A count strictly below the low threshold is a low period. Equal values are neither.
- R6: The high run counter counts consecutive high periods and resets on any other period. When it reaches (control bits 28:26) + 1 it restarts and sets status bit 31, provided control bit 30 is set.
- R7: The low run counter counts consecutive low periods and resets on any other period. When it reaches (control bits 25:23) + 1 it restarts and sets status bit 30, provided control bit 29 is set.
- R8: After an update, an average above the average-high threshold sets status bit 29 when control bit 21 is set. An average below the average-low threshold sets status bit 28 when control bit 20 is set.
- R9: Status bits stay set until software writes the status offset. Each bit written as 1 is cleared.
- R10: A channel interrupts when any status bit 31/30/29/28 is set together with its enable (control bit 30/29/21/20). Channel i drives global status bit 26-i, and the irq output is the OR of all channels.
- R11: Unless both control bit 31 (channel on) and bit 18 (sampling on) are set, the tally, the average and the run counters hold their values, and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | NUM_CH | One activity pulse per channel per cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that software does not write the status offset in the same cycle as it expects a set to be recorded (set wins in that case anyway). They also assume that the run-length fields change only between periods. The period-length check assumes that a period write and the counters reset together. The stimulus meets these conditions. Every write and read happens while the timer is parked on a long period. Events are driven only inside a freshly synchronised short period, never on its final cycle. The next write then parks the timer again before any further period end.

// File: rtl/amon_pkg.sv
`timescale 1ns/1ps
package amon_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int OFS_W  = 6;

  localparam logic [ADDR_W-1:0] GLB_STAT_A = 10'h000;
  localparam logic [ADDR_W-1:0] GLB_PER_A  = 10'h004;
  localparam int CH_BASE   = 'h1C0;
  localparam int CH_STRIDE = 'h040;
  localparam int GLB_IRQ_TOP = 26;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_HI    = 6'h04;
  localparam logic [OFS_W-1:0] OFS_LO    = 6'h08;
  localparam logic [OFS_W-1:0] OFS_LOAD  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_AHI   = 6'h10;
  localparam logic [OFS_W-1:0] OFS_ALO   = 6'h14;
  localparam logic [OFS_W-1:0] OFS_WT    = 6'h18;
  localparam logic [OFS_W-1:0] OFS_AVG   = 6'h20;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h24;

  localparam int ST_RUN_HI = 31;
  localparam int ST_RUN_LO = 30;
  localparam int ST_AVG_HI = 29;
  localparam int ST_AVG_LO = 28;

  typedef struct packed {
    logic       chan_on;
    logic       run_hi_en;
    logic       run_lo_en;
    logic [2:0] run_hi_len;
    logic [2:0] run_lo_len;
    logic       avg_hi_en;
    logic       avg_lo_en;
    logic       sample_on;
    logic [2:0] k;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.chan_on    = w[31];
    c.run_hi_en  = w[30];
    c.run_lo_en  = w[29];
    c.run_hi_len = w[28:26];
    c.run_lo_len = w[25:23];
    c.avg_hi_en  = w[21];
    c.avg_lo_en  = w[20];
    c.sample_on  = w[18];
    c.k          = w[12:10];
    return c;
  endfunction
endpackage

// File: rtl/amon_period_gen.sv
`timescale 1ns/1ps
module amon_period_gen #(
  parameter int UNIT_CYCLES = 4,
  parameter int PER_W       = 8,
  parameter int PER_RST     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_wdata,
  output logic [PER_W-1:0] per_q,
  output logic             strobe
);
  localparam int UNIT_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

  logic [UNIT_W-1:0] unit_q;
  logic [PER_W-1:0]  cnt_q;
  logic              unit_wrap;

  assign unit_wrap = (unit_q == UNIT_W'(UNIT_CYCLES - 1));
  assign strobe    = unit_wrap && (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= PER_W'(PER_RST);
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (per_wr) begin
      per_q  <= per_wdata;
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (unit_wrap) begin
      unit_q <= '0;
      cnt_q  <= (cnt_q == per_q) ? '0 : cnt_q + 1'b1;
    end else begin
      unit_q <= unit_q + 1'b1;
    end
  end

  // independent cycle tally since the last period boundary
  logic [31:0] span_q;
  always_ff @(posedge clk) begin
    if (!rst_n || per_wr || strobe) span_q <= '0;
    else                            span_q <= span_q + 1;
  end

  a_r2_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (span_q == (32'(per_q) + 32'd1) * 32'(UNIT_CYCLES) - 32'd1));
endmodule

// File: rtl/amon_run_ctr.sv
`timescale 1ns/1ps
module amon_run_ctr #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hit,
  input  logic [LEN_W-1:0] limit,
  output logic             fire
);
  logic [LEN_W-1:0] run_q;

  assign fire = step && hit && (run_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                 run_q <= '0;
    else if (step) begin
      if (!hit || fire)         run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/amon_avg.sv
`timescale 1ns/1ps
module amon_avg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [3:0]   shift,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] avg_q,
  output logic [W-1:0] avg_nxt
);
  assign avg_nxt = avg_q - (avg_q >> shift) + (cnt >> shift);

  always_ff @(posedge clk) begin
    if (!rst_n)    avg_q <= '0;
    else if (load) avg_q <= load_val;
    else if (step) avg_q <= avg_nxt;
  end
endmodule

// File: rtl/amon_channel.sv
`timescale 1ns/1ps
module amon_channel
  import amon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              event_i,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctl_q, hi_q, lo_q, ahi_q, alo_q, wt_q, acc_q, status_q;
  logic [DATA_W-1:0] avg_q, avg_nxt, set_v, clr_v, mask_v;
  ctl_t ctl;
  logic active, step, above, below, fire_hi, fire_lo, load_wr, stat_wr;

  assign ctl     = ctl_decode(ctl_q);
  assign active  = ctl.chan_on && ctl.sample_on;
  assign step    = sample && active;
  assign above   = acc_q > hi_q;
  assign below   = acc_q < lo_q;
  assign load_wr = wr_en && (ofs == OFS_LOAD);
  assign stat_wr = wr_en && (ofs == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; hi_q <= '0; lo_q <= '0;
      ahi_q <= '0; alo_q <= '0; wt_q <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_CTRL: ctl_q <= wdata;
        OFS_HI:   hi_q  <= wdata;
        OFS_LO:   lo_q  <= wdata;
        OFS_AHI:  ahi_q <= wdata;
        OFS_ALO:  alo_q <= wdata;
        OFS_WT:   wt_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           acc_q <= '0;
    else if (active) begin
      if (sample)         acc_q <= event_i ? wt_q : '0;
      else if (event_i)   acc_q <= acc_q + wt_q;
    end
  end

  amon_run_ctr #(.LEN_W(3)) u_run_hi (
    .clk(clk), .rst_n(rst_n), .step(step), .hit(above),
    .limit(ctl.run_hi_len), .fire(fire_hi));

  amon_run_ctr #(.LEN_W(3)) u_run_lo (
    .clk(clk), .rst_n(rst_n), .step(step), .hit(below),
    .limit(ctl.run_lo_len), .fire(fire_lo));

  amon_avg #(.W(DATA_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .load(load_wr), .load_val(wdata),
    .step(step), .shift({1'b0, ctl.k} + 4'd1), .cnt(acc_q),
    .avg_q(avg_q), .avg_nxt(avg_nxt));

  always_comb begin
    set_v = '0;
    set_v[ST_RUN_HI] = fire_hi && ctl.run_hi_en;
    set_v[ST_RUN_LO] = fire_lo && ctl.run_lo_en;
    set_v[ST_AVG_HI] = step && ctl.avg_hi_en && (avg_nxt > ahi_q);
    set_v[ST_AVG_LO] = step && ctl.avg_lo_en && (avg_nxt < alo_q);
    mask_v = '0;
    mask_v[ST_RUN_HI] = ctl.run_hi_en;
    mask_v[ST_RUN_LO] = ctl.run_lo_en;
    mask_v[ST_AVG_HI] = ctl.avg_hi_en;
    mask_v[ST_AVG_LO] = ctl.avg_lo_en;
  end

  assign clr_v = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_v) | set_v;
  end

  assign irq_o = |(status_q & mask_v);

  always_comb begin
    case (ofs)
      OFS_CTRL: rdata = ctl_q;
      OFS_HI:   rdata = hi_q;
      OFS_LO:   rdata = lo_q;
      OFS_AHI:  rdata = ahi_q;
      OFS_ALO:  rdata = alo_q;
      OFS_WT:   rdata = wt_q;
      OFS_AVG:  rdata = avg_q;
      OFS_STAT: rdata = status_q;
      default:  rdata = '0;
    endcase
  end

  logic hi_en_q, lo_en_q;
  always_ff @(posedge clk) begin
    hi_en_q <= ctl.run_hi_en;
    lo_en_q <= ctl.run_lo_en;
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r11_hold_avg: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_wr) |=> $stable(avg_q));
  a_r6_run_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_RUN_HI]) |-> hi_en_q);
  a_r7_run_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_RUN_LO]) |-> lo_en_q);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o);
endmodule

// File: rtl/activity_monitor.sv
`timescale 1ns/1ps
module activity_monitor
  import amon_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int UNIT_CYCLES = 4,
  parameter int PER_W       = 8,
  parameter int PER_RST     = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   event_i,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_o
);
  logic [PER_W-1:0]  per_q;
  logic              strobe;
  logic [NUM_CH-1:0] ch_sel, ch_irq;
  logic [DATA_W-1:0] ch_rd [NUM_CH];
  logic [DATA_W-1:0] glb_stat;

  amon_period_gen #(
    .UNIT_CYCLES(UNIT_CYCLES), .PER_W(PER_W), .PER_RST(PER_RST)
  ) u_period (
    .clk(clk), .rst_n(rst_n),
    .per_wr(reg_we && (reg_addr == GLB_PER_A)),
    .per_wdata(reg_wdata[PER_W-1:0]),
    .per_q(per_q), .strobe(strobe));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE_I = CH_BASE + i * CH_STRIDE;
    localparam logic [ADDR_W-1:0] BASE = BASE_I[ADDR_W-1:0];
    assign ch_sel[i] = (reg_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);

    amon_channel u_ch (
      .clk(clk), .rst_n(rst_n), .sample(strobe), .event_i(event_i[i]),
      .wr_en(reg_we && ch_sel[i]), .ofs(reg_addr[OFS_W-1:0]),
      .wdata(reg_wdata), .rdata(ch_rd[i]), .irq_o(ch_irq[i]));
  end

  always_comb begin
    glb_stat = '0;
    for (int i = 0; i < NUM_CH; i++) glb_stat[GLB_IRQ_TOP - i] = ch_irq[i];
  end

  assign irq_o = |ch_irq;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GLB_STAT_A)     reg_rdata = glb_stat;
    else if (reg_addr == GLB_PER_A) reg_rdata = DATA_W'(per_q);
    for (int i = 0; i < NUM_CH; i++)
      if (ch_sel[i]) reg_rdata = ch_rd[i];
  end

  a_r10_irq_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (glb_stat != '0));
endmodule

// File: tb/activity_monitor_tb.sv
`timescale 1ns/1ps
module activity_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;
  localparam int L = (P + 1) * 4;
  localparam logic [9:0] GSTAT = 10'h000, GPER = 10'h004;

  logic clk = 0, rst_n = 0, reg_we = 0, irq;
  logic [1:0] ev = 0;
  logic [9:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_ctl[2], m_wt[2], m_hi[2], m_lo[2], m_ahi[2], m_alo[2];
  logic [31:0] m_avg[2], m_st[2];
  int m_rhi[2], m_rlo[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  activity_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .event_i(ev), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq));

  function automatic logic [9:0] base(int c);
    return 10'(32'h1C0 + c * 32'h40);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctl(bit on, int k, int hl, int ll,
                                         bit rh, bit rl, bit ah, bit al);
    return (32'(on) << 31) | (32'(rh) << 30) | (32'(rl) << 29) |
           (32'(hl) << 26) | (32'(ll) << 23) | (32'(ah) << 21) |
           (32'(al) << 20) | (32'd1 << 18) | (32'(k) << 10);
  endfunction

  task automatic cfg(int c, logic [31:0] ctl, logic [31:0] w, logic [31:0] hi,
                     logic [31:0] lo, logic [31:0] ahi, logic [31:0] alo);
    wr(base(c) + 10'h00, ctl); m_ctl[c] = ctl;
    wr(base(c) + 10'h04, hi);  m_hi[c]  = hi;
    wr(base(c) + 10'h08, lo);  m_lo[c]  = lo;
    wr(base(c) + 10'h10, ahi); m_ahi[c] = ahi;
    wr(base(c) + 10'h14, alo); m_alo[c] = alo;
    wr(base(c) + 10'h18, w);   m_wt[c]  = w;
  endtask

  task automatic load_avg(int c, logic [31:0] v);
    wr(base(c) + 10'h0C, v); m_avg[c] = v;
  endtask

  task automatic clr_st(int c);
    wr(base(c) + 10'h24, 32'hFFFF_FFFF); m_st[c] = 0;
  endtask

  function automatic void model_step(int c, int n);
    logic [31:0] cnt, nxt;
    int k, hl, ll;
    if (!(m_ctl[c][31] && m_ctl[c][18])) return;
    cnt = 32'(n) * m_wt[c];
    k = int'(m_ctl[c][12:10]); hl = int'(m_ctl[c][28:26]); ll = int'(m_ctl[c][25:23]);
    if (cnt > m_hi[c]) begin
      if (m_rhi[c] == hl) begin m_rhi[c] = 0; if (m_ctl[c][30]) m_st[c][31] = 1; end
      else m_rhi[c]++;
    end else m_rhi[c] = 0;
    if (cnt < m_lo[c]) begin
      if (m_rlo[c] == ll) begin m_rlo[c] = 0; if (m_ctl[c][29]) m_st[c][30] = 1; end
      else m_rlo[c]++;
    end else m_rlo[c] = 0;
    nxt = m_avg[c] - (m_avg[c] >> (k + 1)) + (cnt >> (k + 1));
    m_avg[c] = nxt;
    if (m_ctl[c][21] && nxt > m_ahi[c]) m_st[c][29] = 1;
    if (m_ctl[c][20] && nxt < m_alo[c]) m_st[c][28] = 1;
  endfunction

  function automatic bit m_irq(int c);
    return (m_st[c][31] & m_ctl[c][30]) | (m_st[c][30] & m_ctl[c][29]) |
           (m_st[c][29] & m_ctl[c][21]) | (m_st[c][28] & m_ctl[c][20]);
  endfunction

  // sync the timer, drive n0/n1 events, let one period close, then park
  task automatic run_period(int n0, int n1);
    @(negedge clk); reg_we = 1; reg_addr = GPER; reg_wdata = P;
    @(negedge clk); reg_we = 0;
    for (int c = 1; c < L; c++) begin
      ev[0] = (c <= n0); ev[1] = (c <= n1);
      @(negedge clk);
    end
    ev = 0;
    @(negedge clk);
    reg_we = 1; reg_addr = GPER; reg_wdata = 255;
    @(negedge clk); reg_we = 0;
    model_step(0, n0);
    model_step(1, n1);
  endtask

  task automatic check_all();
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      rd(base(c) + 10'h20, v);
      chk((m_ctl[c][31] && m_ctl[c][18]) ? "R4 avg" : "R11 held avg", v, m_avg[c]);
      rd(base(c) + 10'h24, v);
      chk("R6 run-high status", {31'd0, v[31]}, {31'd0, m_st[c][31]});
      chk("R7 run-low status", {31'd0, v[30]}, {31'd0, m_st[c][30]});
      chk("R8 avg status", {30'd0, v[29:28]}, {30'd0, m_st[c][29:28]});
    end
    rd(GSTAT, v);
    chk("R10 global status", v, (32'(m_irq(0)) << 26) | (32'(m_irq(1)) << 25));
    chk("R10 irq pin", {31'd0, irq}, {31'd0, m_irq(0) | m_irq(1)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      m_ctl[c] = 0; m_wt[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_ahi[c] = 0;
      m_alo[c] = 0; m_avg[c] = 0; m_st[c] = 0; m_rhi[c] = 0; m_rlo[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(GPER, v);                 chk("R2 reset period", v, 32'd11);
    rd(base(0) + 10'h20, v);     chk("R4 reset avg", v, 0);
    rd(base(1) + 10'h24, v);     chk("R9 reset status", v, 0);
    rd(GSTAT, v);                chk("R10 reset global", v, 0);
    chk("R10 reset irq", {31'd0, irq}, 0);

    // register readback
    cfg(0, mk_ctl(1, 0, 0, 0, 1, 1, 0, 0), 1, 5, 3, 32'hFFFF_FFFF, 0);
    cfg(1, 32'h0, 1024, 6000, 3000, 5000, 2000);
    rd(base(0) + 10'h04, v);     chk("R1 high threshold", v, 5);
    rd(base(1) + 10'h18, v);     chk("R1 weight", v, 1024);
    rd(base(1) + 10'h14, v);     chk("R1 avg low threshold", v, 2000);
    rd(base(0) + 10'h00, v);     chk("R1 control", v, m_ctl[0]);
    wr(GPER, P); rd(GPER, v);    chk("R2 period readback", v, P);

    // R5 threshold equality boundaries
    run_period(5, 0); rd(base(0) + 10'h24, v); chk("R5 equal high", {31'd0, v[31]}, 0);
    run_period(6, 0); rd(base(0) + 10'h24, v); chk("R5 above high", {31'd0, v[31]}, 1);
    clr_st(0);
    run_period(3, 0); rd(base(0) + 10'h24, v); chk("R5 equal low", {31'd0, v[30]}, 0);
    run_period(2, 0); rd(base(0) + 10'h24, v); chk("R5 below low", {31'd0, v[30]}, 1);
    check_all();
    clr_st(0); rd(base(0) + 10'h24, v); chk("R9 cleared", v, 0);

    // R2/R3 full-period boundary: L-1 events all counted
    cfg(0, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0), 7, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0);
    load_avg(0, 0);
    run_period(L - 1, 0);
    rd(base(0) + 10'h20, v); chk("R3 full period count", v, 32'((L - 1) * 7) >> 1);

    // sweep shift, run lengths, enable and event mixes
    for (int k = 0; k < 4; k++) begin
      load_avg(0, 32'(100 * k + 7));
      load_avg(1, 32'd4000);
      rd(base(0) + 10'h20, v); chk("R4 load avg", v, m_avg[0]);
      for (int cf = 0; cf < 4; cf++) begin
        cfg(0, mk_ctl(1, k, cf % 2, cf, 1, 1, 1, cf != 1), 3, 20, 10, 15, 5);
        cfg(1, mk_ctl(cf != 3, k, 0, 2, 1, 1, 1, 1), 1024, 6000, 3000, 5000, 2000);
        for (int n = 0; n <= 12; n++) begin
          run_period(n, 12 - n);
          check_all();
          if (n % 5 == 4) begin
            clr_st(0); clr_st(1);
            rd(base(1) + 10'h24, v); chk("R9 write-ones clear", v, 0);
          end
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule